// File: doc/BRIEF.md
# Reconfigurable Quad/Dual Width-Matching FIFO Bank

This block is a synchronous FIFO bank whose storage is a fixed bit budget, split among its channels when master reset is applied. With the mode input low it runs as four separate FIFOs with 10-bit ports. With the mode input high it runs as two FIFOs on channels 0 and 2. Their write and read widths are chosen separately as 10 or 20 bits, and the choice is shared by both channels. A rate input selects double-data-rate words. In that setting one word carries two 10-bit beats side by side on the bus, with the first beat in the low bits.

All configuration inputs are captured only while reset is high. Each channel has its own write enable, read enable, data buses and four status flags: empty, full, almost-empty and almost-full. Both sides run on one clock. When the write and read widths differ, the channel packs two narrow writes into one wide read word, or splits one wide write into two narrow reads. In both cases the low half comes first.

Top module: `qd_fifo_bank`

## Requirements
- R1: With the mode input low, channels 0 to 3 are four independent FIFOs with 10-bit words; each returns its own words in write order, and activity on one channel does not change another.
- R2: With the mode input high, channels 0 and 2 are independent FIFOs whose write and read widths (10 bits when the width input is low, 20 when high) are the same for both channels.
- R3: Each store holds ROWS*4 ten-bit units. A channel owns one store in quad mode and two stores in dual mode. Its depth in words is its unit capacity divided by the units per word, so with ROWS=4: quad 10-bit = 16 words, dual 10-bit = 32, dual 20-bit write = 16.
- R4: With 10-bit writes and 20-bit reads, two writes form one read word, with the first write in bits [9:0]. Empty stays high while fewer than two units are stored.
- R5: With 20-bit writes and 10-bit reads, a written word is read back as bits [9:0] first, then bits [19:10]. Full is high whenever fewer than two units are free.
- R6: With the rate input high, each word is two 10-bit beats (first beat in the low bits), and each channel's word depth is half its single-rate depth (quad: 8 words of 20 bits).
- R7: Empty, full, almost-empty (stored read words <= AE_LVL) and almost-full (free write words <= AF_LVL) are computed from registered occupancy. They change in the cycle after the accepted access.
- R8: A write while full and a read while empty are ignored. Pointers, stored data and the last read word are left unchanged.
- R9: In dual mode, every flag and the read data of channels 1 and 3 are held at 0, and their enables have no effect.
- R10: Configuration inputs are sampled only while reset is high; later changes have no effect until the next reset.
- R11: Read data appears one cycle after an accepted read and holds until the channel's next accepted read.
- R12: After reset all channels are empty with the almost-empty flag high, the full and almost-full flags low, and read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst | input | 1 | Synchronous active-high master reset; configuration is sampled while high |
| cfg_dual | input | 1 | 0 = four channels, 1 = two channels (0 and 2) |
| cfg_wide_in | input | 1 | Dual mode write width: 0 = 10 bits, 1 = 20 bits |
| cfg_wide_out | input | 1 | Dual mode read width: 0 = 10 bits, 1 = 20 bits |
| cfg_ddr | input | 1 | 1 = each word holds two beats (double data rate) |
| wr_en | input | 4 | Per-channel write enable |
| wr_data | input | 160 | Per-channel write word, channel c in bits [40c+39:40c] |
| rd_en | input | 4 | Per-channel read enable |
| rd_data | output | 160 | Per-channel read word, channel c in bits [40c+39:40c], unused bits 0 |
| empty | output | 4 | Per-channel empty flag |
| full | output | 4 | Per-channel full flag |
| aempty | output | 4 | Per-channel almost-empty flag |
| afull | output | 4 | Per-channel almost-full flag |

## Verification
The bench uses the default parameters: ROWS=4 gives 16 units per store and a 640-bit budget, and AE_LVL and AF_LVL are both 2. With stores this small, every full boundary (16, 32, 8 words) can be reached with a few dozen writes. A dual-mode channel is filled past the point where its pointer crosses from its first store into the second, and the read order is then checked across that seam. Both flag thresholds are crossed with short write runs in the same tests.

// File: rtl/qd_pkg.sv
`timescale 1ns/1ps
package qd_pkg;
  localparam int UNIT_W = 10;
  localparam int LANES  = 4;
  localparam int NCH    = 4;
  localparam int BUS_W  = UNIT_W * LANES;

  typedef struct packed {
    logic dual;
    logic win;
    logic wout;
    logic ddr;
  } qd_cfg_t;

  // log2 of 10-bit units per write word
  function automatic logic [1:0] wr_shift(qd_cfg_t c);
    return {1'b0, c.dual & c.win} + {1'b0, c.ddr};
  endfunction

  // log2 of 10-bit units per read word
  function automatic logic [1:0] rd_shift(qd_cfg_t c);
    return {1'b0, c.dual & c.wout} + {1'b0, c.ddr};
  endfunction
endpackage

// File: rtl/qd_lane_store.sv
`timescale 1ns/1ps
module qd_lane_store
  import qd_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int RB   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [RB-1:0]    wrow,
  input  logic [1:0]       woff,
  input  logic [1:0]       wsh,
  input  logic [BUS_W-1:0] wdata,
  input  logic             re,
  input  logic [RB-1:0]    rrow,
  output logic [BUS_W-1:0] q
);
  // One simple dual-port memory per 10-bit lane; an aligned access of
  // 1, 2 or 4 units never wraps across a row.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [UNIT_W-1:0] mem [ROWS];
    logic [2:0]        idx;
    logic              lane_we;
    logic [UNIT_W-1:0] lane_d;

    assign idx     = 3'(l) - {1'b0, woff};
    assign lane_we = we && (3'(l) >= {1'b0, woff}) && (idx < (3'd1 << wsh));
    assign lane_d  = wdata[idx[1:0]*UNIT_W +: UNIT_W];

    always_ff @(posedge clk) begin
      if (lane_we) mem[wrow] <= lane_d;
    end

    always_ff @(posedge clk) begin
      if (rst)     q[l*UNIT_W +: UNIT_W] <= '0;
      else if (re) q[l*UNIT_W +: UNIT_W] <= mem[rrow];
    end
  end
endmodule

// File: rtl/qd_chan_ctrl.sv
`timescale 1ns/1ps
module qd_chan_ctrl
  import qd_pkg::*;
#(
  parameter int QU     = 16,
  parameter int PW     = $clog2(2*QU),
  parameter int AE_LVL = 2,
  parameter int AF_LVL = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  qd_cfg_t       cfg,
  input  logic          active,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          push,
  output logic          pop,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic          empty,
  output logic          full,
  output logic          aempty,
  output logic          afull
);
  localparam int CW = PW + 1;

  logic [CW-1:0] cnt, cap, free_u, wk, rk;
  logic [1:0]    wsh, rsh;
  logic [PW-1:0] pmask;
  logic          full_i, empty_i;

  assign wsh    = wr_shift(cfg);
  assign rsh    = rd_shift(cfg);
  assign wk     = CW'(1) << wsh;
  assign rk     = CW'(1) << rsh;
  assign cap    = cfg.dual ? CW'(2*QU) : CW'(QU);
  assign pmask  = cfg.dual ? PW'(2*QU-1) : PW'(QU-1);
  assign free_u = cap - cnt;

  assign full_i  = free_u < wk;
  assign empty_i = cnt < rk;
  assign push    = active & wr_en & ~full_i;
  assign pop     = active & rd_en & ~empty_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= (wptr + wk[PW-1:0]) & pmask;
      if (pop)  rptr <= (rptr + rk[PW-1:0]) & pmask;
      cnt <= cnt + (push ? wk : '0) - (pop ? rk : '0);
    end
  end

  assign empty  = active & empty_i;
  assign full   = active & full_i;
  assign aempty = active & ((cnt >> rsh) <= CW'(AE_LVL));
  assign afull  = active & ((free_u >> wsh) <= CW'(AF_LVL));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= cap);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en) |=> $stable(wptr));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en) |=> $stable(rptr));
  assert_flag_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));
endmodule

// File: rtl/qd_fifo_bank.sv
`timescale 1ns/1ps
module qd_fifo_bank
  import qd_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int AE_LVL = 2,
  parameter int AF_LVL = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_dual,
  input  logic                 cfg_wide_in,
  input  logic                 cfg_wide_out,
  input  logic                 cfg_ddr,
  input  logic [NCH-1:0]       wr_en,
  input  logic [NCH*BUS_W-1:0] wr_data,
  input  logic [NCH-1:0]       rd_en,
  output logic [NCH*BUS_W-1:0] rd_data,
  output logic [NCH-1:0]       empty,
  output logic [NCH-1:0]       full,
  output logic [NCH-1:0]       aempty,
  output logic [NCH-1:0]       afull
);
  localparam int QU = ROWS * LANES;   // units per store
  localparam int QB = $clog2(QU);
  localparam int PW = QB + 1;         // pointer covers two stores
  localparam int RB = $clog2(ROWS);

  qd_cfg_t        cfg_q;
  logic [1:0]     wsh, rsh;
  logic [BUS_W-1:0] rmask;
  logic [PW-1:0]  wptr [NCH];
  logic [PW-1:0]  rptr [NCH];
  logic [BUS_W-1:0] sq [NCH];
  logic [NCH-1:0] push, pop, act;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= {cfg_dual, cfg_wide_in, cfg_wide_out, cfg_ddr};
  end

  assign wsh = wr_shift(cfg_q);
  assign rsh = rd_shift(cfg_q);

  always_comb begin
    for (int l = 0; l < LANES; l++)
      rmask[l*UNIT_W +: UNIT_W] = (l < (1 << rsh)) ? '1 : '0;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [1:0] rsrc_q;
    logic [1:0] roff_q;

    assign act[c] = ~cfg_q.dual | ((c % 2) == 0);

    qd_chan_ctrl #(.QU(QU), .PW(PW), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL)) u_ctrl (
      .clk(clk), .rst(rst), .cfg(cfg_q), .active(act[c]),
      .wr_en(wr_en[c]), .rd_en(rd_en[c]), .push(push[c]), .pop(pop[c]),
      .wptr(wptr[c]), .rptr(rptr[c]),
      .empty(empty[c]), .full(full[c]), .aempty(aempty[c]), .afull(afull[c])
    );

    // remember which store and lane the last accepted read came from
    always_ff @(posedge clk) begin
      if (rst) begin
        rsrc_q <= 2'(c);
        roff_q <= '0;
      end else if (pop[c]) begin
        rsrc_q <= 2'(c) + {1'b0, cfg_q.dual & rptr[c][QB]};
        roff_q <= rptr[c][1:0];
      end
    end

    assign rd_data[c*BUS_W +: BUS_W] =
      act[c] ? ((sq[rsrc_q] >> (roff_q * UNIT_W)) & rmask) : '0;
  end

  for (genvar s = 0; s < NCH; s++) begin : g_st
    logic [1:0] own;
    logic       sel_w, sel_r;

    assign own   = cfg_q.dual ? 2'(s & 2) : 2'(s);
    assign sel_w = ~cfg_q.dual | (wptr[own][QB] == 1'(s % 2));
    assign sel_r = ~cfg_q.dual | (rptr[own][QB] == 1'(s % 2));

    qd_lane_store #(.ROWS(ROWS), .RB(RB)) u_store (
      .clk(clk), .rst(rst),
      .we(push[own] & sel_w), .wrow(wptr[own][QB-1:2]), .woff(wptr[own][1:0]),
      .wsh(wsh), .wdata(wr_data[own*BUS_W +: BUS_W]),
      .re(pop[own] & sel_r), .rrow(rptr[own][QB-1:2]), .q(sq[s])
    );
  end

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(cfg_q));
  assert_idle_outputs_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_q.dual |-> !(empty[1] || full[1] || aempty[1] || afull[1] ||
                     empty[3] || full[3] || aempty[3] || afull[3]));
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    ((rd_en & ~empty) == '0) |=> $stable(rd_data));
endmodule

// File: tb/qd_fifo_bank_tb.sv
`timescale 1ns/1ps
module qd_fifo_bank_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_dual = 1'b0, cfg_wide_in = 1'b0, cfg_wide_out = 1'b0, cfg_ddr = 1'b0;
  logic [3:0]   wr_en = '0, rd_en = '0;
  logic [159:0] wr_data = '0;
  logic [159:0] rd_data;
  logic [3:0]   empty, full, aempty, afull;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  qd_fifo_bank dut_i (
    .clk(clk), .rst(rst), .cfg_dual(cfg_dual), .cfg_wide_in(cfg_wide_in),
    .cfg_wide_out(cfg_wide_out), .cfg_ddr(cfg_ddr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .empty(empty), .full(full), .aempty(aempty), .afull(afull)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic do_reset(input logic d, input logic wi, input logic wo, input logic r);
    cfg_dual = d; cfg_wide_in = wi; cfg_wide_out = wo; cfg_ddr = r;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int ch, input logic [39:0] d);
    wr_en[ch] = 1'b1;
    wr_data[ch*40 +: 40] = d;
    @(negedge clk);
    wr_en[ch] = 1'b0;
  endtask

  task automatic rd(input int ch, output logic [39:0] d);
    rd_en[ch] = 1'b1;
    @(negedge clk);
    rd_en[ch] = 1'b0;
    d = rd_data[ch*40 +: 40];
  endtask

  task automatic t_reset();
    do_reset(0, 0, 0, 0);
    chk("R12 empty", {36'b0, empty}, 40'hF);
    chk("R12 full", {36'b0, full}, 40'h0);
    chk("R12 aempty", {36'b0, aempty}, 40'hF);
    chk("R12 afull", {36'b0, afull}, 40'h0);
    chk("R12 rd_data", {39'b0, |rd_data}, 40'h0);
  endtask

  task automatic t_quad_basic();
    logic [39:0] d;
    wr(0, 40'h001); wr(0, 40'h002); wr(1, 40'h101); wr(3, 40'h301);
    chk("R7 empty after writes", {36'b0, empty}, 40'h4);
    chk("R7 aempty small count", {36'b0, aempty}, 40'hF);
    rd(1, d); chk("R1 ch1 word", d, 40'h101);
    rd(0, d); chk("R1 ch0 first", d, 40'h001);
    rd(0, d); chk("R1 ch0 second", d, 40'h002);
    chk("R1 ch0 drained", {39'b0, empty[0]}, 40'h1);
    @(negedge clk);
    chk("R11 ch0 hold", rd_data[39:0], 40'h002);
    chk("R11 ch1 hold", rd_data[79:40], 40'h101);
    rd(3, d); chk("R1 ch3 word", d, 40'h301);
  endtask

  task automatic t_quad_depth();
    logic [39:0] d;
    for (int i = 0; i < 13; i++) wr(2, 40'h200 + 40'(i));
    chk("R7 afull below level", {39'b0, afull[2]}, 40'h0);
    chk("R7 aempty above level", {39'b0, aempty[2]}, 40'h0);
    wr(2, 40'h20D);
    chk("R7 afull at level", {39'b0, afull[2]}, 40'h1);
    wr(2, 40'h20E);
    chk("R3 not full at 15", {39'b0, full[2]}, 40'h0);
    wr(2, 40'h20F);
    chk("R3 full at 16", {39'b0, full[2]}, 40'h1);
    wr(2, 40'h3FF);
    chk("R8 still full", {39'b0, full[2]}, 40'h1);
    for (int i = 0; i < 16; i++) begin
      rd(2, d);
      chk("R3 quad order", d, 40'h200 + 40'(i));
    end
    chk("R7 empty after drain", {39'b0, empty[2]}, 40'h1);
    chk("R7 aempty after drain", {39'b0, aempty[2]}, 40'h1);
    rd(2, d);
    chk("R8 underflow keeps data", d, 40'h20F);
    wr(2, 40'h155);
    rd(2, d);
    chk("R8 pointers intact", d, 40'h155);
  endtask

  task automatic t_dual_pack();
    logic [39:0] d;
    do_reset(1, 0, 1, 0);
    wr(0, 40'h011);
    chk("R4 half word empty", {39'b0, empty[0]}, 40'h1);
    wr(0, 40'h022);
    chk("R4 full word ready", {39'b0, empty[0]}, 40'h0);
    rd(0, d);
    chk("R4 packed low first", d, 40'h08811);
    wr(1, 40'h3AA);
    rd(1, d);
    chk("R9 ch1 data", d, 40'h0);
    chk("R9 ch1/3 flags", {32'b0, empty[1], full[1], aempty[1], afull[1],
                           empty[3], full[3], aempty[3], afull[3]}, 40'h0);
    chk("R9 ch2 untouched", {39'b0, empty[2]}, 40'h1);
    wr(2, 40'h005); wr(2, 40'h006);
    rd(2, d);
    chk("R2 ch2 same widths", d, 40'h01805);
  endtask

  task automatic t_dual_split();
    logic [39:0] d;
    do_reset(1, 1, 0, 0);
    for (int i = 0; i < 15; i++) wr(0, (40'(12'h100 + i) << 10) | 40'(i));
    chk("R5 not full at 15", {39'b0, full[0]}, 40'h0);
    wr(0, (40'h10F << 10) | 40'h00F);
    chk("R3 full at 16 wide", {39'b0, full[0]}, 40'h1);
    wr(0, 40'hFFFFF);
    rd(0, d); chk("R5 low half first", d, 40'h000);
    chk("R5 one free unit still full", {39'b0, full[0]}, 40'h1);
    rd(0, d); chk("R5 high half second", d, 40'h100);
    chk("R5 two free units", {39'b0, full[0]}, 40'h0);
    for (int i = 1; i < 16; i++) begin
      rd(0, d); chk("R5 split low", d, 40'(i));
      rd(0, d); chk("R5 split high", d, 40'(12'h100 + i));
    end
    chk("R5 drained", {39'b0, empty[0]}, 40'h1);
  endtask

  task automatic t_ddr();
    logic [39:0] d;
    do_reset(0, 0, 0, 1);
    for (int i = 0; i < 7; i++) wr(3, (40'(12'h300 + i) << 10) | 40'(12'h080 + i));
    chk("R6 not full at 7", {39'b0, full[3]}, 40'h0);
    wr(3, (40'h307 << 10) | 40'h087);
    chk("R6 full at 8", {39'b0, full[3]}, 40'h1);
    for (int i = 0; i < 8; i++) begin
      rd(3, d);
      chk("R6 beat pair", d, (40'(12'h300 + i) << 10) | 40'(12'h080 + i));
    end
  endtask

  task automatic t_dual_depth();
    logic [39:0] d;
    do_reset(1, 0, 0, 0);
    for (int i = 0; i < 31; i++) wr(2, 40'h040 + 40'(i));
    chk("R3 dual not full at 31", {39'b0, full[2]}, 40'h0);
    wr(2, 40'h05F);
    chk("R3 dual full at 32", {39'b0, full[2]}, 40'h1);
    chk("R2 ch0 independent", {39'b0, empty[0]}, 40'h1);
    for (int i = 0; i < 32; i++) begin
      rd(2, d);
      chk("R2 dual order across stores", d, 40'h040 + 40'(i));
    end
  endtask

  task automatic t_cfg_hold();
    logic [39:0] d;
    do_reset(0, 0, 0, 0);
    chk("R12 reset clears", {36'b0, empty}, 40'hF);
    cfg_dual = 1'b1; cfg_wide_in = 1'b1; cfg_ddr = 1'b1;
    @(negedge clk);
    wr(1, 40'hFFAB);
    chk("R10 ch1 still live", {39'b0, empty[1]}, 40'h0);
    rd(1, d);
    chk("R10 10-bit word kept", d, 40'h3AB);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_quad_basic();
    t_quad_depth();
    t_dual_pack();
    t_dual_split();
    t_ddr();
    t_dual_depth();
    t_cfg_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule